// File: doc/BRIEF.md
# Serial Configuration Loader with Latch Routing

This block receives 21-bit configuration words over a three-wire serial port (shift clock, data, load strobe) and routes each word to one of four internal latches. All three pins are brought into the core clock domain through a synchronizer chain, and their rising edges are detected there. Every detected shift-clock edge appends one data bit to a 21-bit shift register, most significant bit first. A detected load-strobe edge then copies the word into the latch that its two lowest bits select.

The latches drive parallel fields to the rest of a frequency synthesizer. These fields are the reference divide value, the A and B counter values, an output-mux select, power-down controls, detector polarity, a charge-pump high-impedance control, the fast-lock controls and a timer code. A write to the initialization latch updates the function fields and also produces a single-cycle counter-reset pulse. A reference word that carries a divide value of zero is rejected, and the rejection is flagged for one cycle.

Top module: `syn_cfg_loader`

## Requirements
- R1: After reset every field output, `ctr_rst` and `ref_err` are zero.
- R2: Each synchronized rising edge of `ser_clk` shifts `ser_data` into the shift register at the low end, so the first bit sent ends up as word bit 20. Only the most recent 21 bits are kept.
- R3: A loaded word with bits [1:0] = 00 is a reference word. Its bits [15:2] go to `ref_div`, bits [19:16] go to `ref_test` and bit 20 goes to `ld_prec`. Divide values from 1 to 16383 are accepted.
- R4: A loaded word with bits [1:0] = 01 is a counter word. Its bits [6:2] go to `a_cnt`, bits [19:7] go to `b_cnt` and bit 20 goes to `cp_gain`.
- R5: A loaded word with bits [1:0] = 10 is a function word. Its fields are mapped as follows:
  - bits [4:2] go to `mux_sel`;
  - bits [6:5] go to `pwr_dn`;
  - bit 7 goes to `pd_pol`;
  - bit 8 goes to `cp_hiz`;
  - bit 9 goes to `fl_en`;
  - bit 10 goes to `fl_mode`;
  - bits [14:11] go to `fl_timer`;
  - bits [20:15] have no effect.
- R6: A loaded word with bits [1:0] = 11 updates the same function fields as R5. It also raises `ctr_rst` for exactly one clock cycle. A function word (10) never raises `ctr_rst`.
- R7: A reference word whose bits [15:2] are zero leaves `ref_div`, `ref_test` and `ld_prec` unchanged, and it raises `ref_err` for exactly one cycle.
- R8: Shifting without a load-strobe edge changes no field output. A load changes only the latch that the word selects.
- R9: When more than 21 bits are shifted before a load, only the last 21 bits are used.
- R10: Field outputs change on the (SYNC_STAGES+1)-th rising `clk` edge after `ser_le` rises at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe, acts on rising edge |
| ref_div | output | 14 | Reference divide value |
| ref_test | output | 4 | Test-mode code (0000 in normal use) |
| ld_prec | output | 1 | Lock-detect precision select |
| a_cnt | output | 5 | A counter value |
| b_cnt | output | 13 | B counter value |
| cp_gain | output | 1 | Charge-pump gain select |
| mux_sel | output | 3 | Output-mux select |
| pwr_dn | output | 2 | Power-down controls |
| pd_pol | output | 1 | Phase-detector polarity |
| cp_hiz | output | 1 | Charge-pump high-impedance control |
| fl_en | output | 1 | Fast-lock enable |
| fl_mode | output | 1 | Fast-lock mode |
| fl_timer | output | 4 | Fast-lock timer code |
| ctr_rst | output | 1 | One-cycle counter-reset pulse |
| ref_err | output | 1 | One-cycle flag for a rejected zero divide value |

## Verification
The bench builds the block with SYNC_STAGES = 3 rather than the default of 2. This makes the latency requirement test a depth that differs from the default, so a design that hard-codes a two-flop pipeline misses the predicted update edge. A behavioural model replays the pin history at that depth and compares every field, the reset pulse and the error flag on every cycle. The bench also runs these cases:
- an over-long shift of 25 bits;
- a rejected zero divide value;
- the maximum divide value;
- a function word with its unused upper bits set.

// File: rtl/syn_cfg_pkg.sv
`timescale 1ns/1ps
package syn_cfg_pkg;
  localparam int WORD_W = 21;
  localparam int SEL_W  = 2;
  localparam int PAY_W  = WORD_W - SEL_W;

  typedef enum logic [SEL_W-1:0] {
    DST_REF  = 2'b00,
    DST_AB   = 2'b01,
    DST_FUNC = 2'b10,
    DST_INIT = 2'b11
  } dst_e;

  // Payload views: word[20:2]
  typedef struct packed {
    logic        ld_prec;   // word[20]
    logic [3:0]  test;      // word[19:16]
    logic [13:0] div;       // word[15:2]
  } ref_t;

  typedef struct packed {
    logic        gain;      // word[20]
    logic [12:0] b;         // word[19:7]
    logic [4:0]  a;         // word[6:2]
  } ab_t;

  // Function view: word[14:2]
  typedef struct packed {
    logic [3:0] timer;      // word[14:11]
    logic       fl_mode;    // word[10]
    logic       fl_en;      // word[9]
    logic       cp_hiz;     // word[8]
    logic       pd_pol;     // word[7]
    logic [1:0] pwr_dn;     // word[6:5]
    logic [2:0] mux;        // word[4:2]
  } func_t;

  localparam int FUNC_W = $bits(func_t);
endpackage

// File: rtl/syn_cfg_pinsync.sv
`timescale 1ns/1ps
module syn_cfg_pinsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk_i,
  input  logic ser_data_i,
  input  logic ser_le_i,
  output logic clk_rise_o,
  output logic le_rise_o,
  output logic data_o
);
  localparam int PW    = 3;
  localparam int B_DAT = 0;
  localparam int B_CLK = 1;
  localparam int B_LE  = 2;

  logic [PW-1:0] chain_q [STAGES];
  logic [PW-1:0] chain_d [STAGES];
  logic [PW-1:0] prev_q, prev_d, cur;

  // Synchronizer chain, one generated stage per flop level
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_comb chain_d[g] = {ser_le_i, ser_clk_i, ser_data_i};
    end else begin : g_next
      always_comb chain_d[g] = chain_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= '0;
      else        chain_q[g] <= chain_d[g];
    end
  end

  assign cur = chain_q[STAGES-1];

  always_comb prev_d = cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign clk_rise_o = cur[B_CLK] & ~prev_q[B_CLK];
  assign le_rise_o  = cur[B_LE]  & ~prev_q[B_LE];
  assign data_o     = cur[B_DAT];

  // An edge needs a low sample followed by a high one, so two in a row cannot occur
  p_clk_edge_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clk_rise_o |=> !clk_rise_o);
  p_le_edge_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    le_rise_o |=> !le_rise_o);
endmodule

// File: rtl/syn_cfg_shift.sv
`timescale 1ns/1ps
module syn_cfg_shift
  import syn_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sreg_q, sreg_d;

  // New bit enters at bit 0; the oldest of the last WORD_W bits ends at the top
  always_comb sreg_d = {sreg_q[WORD_W-2:0], bit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sreg_q <= '0;
    else if (shift_en_i) sreg_q <= sreg_d;
  end

  assign word_o = sreg_q;

  p_shift_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en_i |=> $stable(sreg_q));
  p_shift_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en_i |=> (sreg_q[0] == $past(bit_i)));
endmodule

// File: rtl/syn_cfg_latches.sv
`timescale 1ns/1ps
module syn_cfg_latches
  import syn_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en_i,
  input  logic [WORD_W-1:0] word_i,
  output ref_t              ref_o,
  output ab_t               ab_o,
  output func_t             func_o,
  output logic              ctr_rst_o,
  output logic              ref_err_o
);
  dst_e              dst;
  logic [PAY_W-1:0]  payload;
  ref_t              ref_new;
  logic              div_zero;
  logic              ref_we, ref_rej, ab_we, func_we, init_we;
  ref_t              ref_q;
  ab_t               ab_q;
  func_t             func_q;
  logic              ctr_rst_q, ref_err_q;

  // Destination decode and write enables
  always_comb begin
    dst      = dst_e'(word_i[SEL_W-1:0]);
    payload  = word_i[WORD_W-1:SEL_W];
    ref_new  = ref_t'(payload);
    div_zero = (ref_new.div == '0);
    ref_we   = load_en_i && (dst == DST_REF) && !div_zero;
    ref_rej  = load_en_i && (dst == DST_REF) &&  div_zero;
    ab_we    = load_en_i && (dst == DST_AB);
    init_we  = load_en_i && (dst == DST_INIT);
    func_we  = load_en_i && ((dst == DST_FUNC) || (dst == DST_INIT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ref_q <= '0;
    else if (ref_we) ref_q <= ref_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ab_q <= '0;
    else if (ab_we) ab_q <= ab_t'(payload);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       func_q <= '0;
    else if (func_we) func_q <= func_t'(word_i[FUNC_W+SEL_W-1:SEL_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_rst_q <= 1'b0;
      ref_err_q <= 1'b0;
    end else begin
      ctr_rst_q <= init_we;
      ref_err_q <= ref_rej;
    end
  end

  assign ref_o     = ref_q;
  assign ab_o      = ab_q;
  assign func_o    = func_q;
  assign ctr_rst_o = ctr_rst_q;
  assign ref_err_o = ref_err_q;

  p_ctr_rst_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_rst_q |=> !ctr_rst_q);
  p_ctr_rst_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_rst_q |-> $past(load_en_i));
  p_div_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_q.div != '0) |=> (ref_q.div != '0));
  p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_err_q |-> ($past(load_en_i) && $stable(ref_q)));
  p_hold_no_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en_i |=> ($stable(ref_q) && $stable(ab_q) && $stable(func_q)));
endmodule

// File: rtl/syn_cfg_loader.sv
`timescale 1ns/1ps
module syn_cfg_loader
  import syn_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_data,
  input  logic        ser_le,
  output logic [13:0] ref_div,
  output logic [3:0]  ref_test,
  output logic        ld_prec,
  output logic [4:0]  a_cnt,
  output logic [12:0] b_cnt,
  output logic        cp_gain,
  output logic [2:0]  mux_sel,
  output logic [1:0]  pwr_dn,
  output logic        pd_pol,
  output logic        cp_hiz,
  output logic        fl_en,
  output logic        fl_mode,
  output logic [3:0]  fl_timer,
  output logic        ctr_rst,
  output logic        ref_err
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_core_n;
  logic                  clk_rise, le_rise, data_s;
  logic [WORD_W-1:0]     word;
  ref_t                  ref_l;
  ab_t                   ab_l;
  func_t                 func_l;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[RST_STAGES-1];

  syn_cfg_pinsync #(.STAGES(SYNC_STAGES)) u_pinsync (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .ser_clk_i  (ser_clk),
    .ser_data_i (ser_data),
    .ser_le_i   (ser_le),
    .clk_rise_o (clk_rise),
    .le_rise_o  (le_rise),
    .data_o     (data_s)
  );

  syn_cfg_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .shift_en_i (clk_rise),
    .bit_i      (data_s),
    .word_o     (word)
  );

  syn_cfg_latches u_latches (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load_en_i (le_rise),
    .word_i    (word),
    .ref_o     (ref_l),
    .ab_o      (ab_l),
    .func_o    (func_l),
    .ctr_rst_o (ctr_rst),
    .ref_err_o (ref_err)
  );

  assign ref_div  = ref_l.div;
  assign ref_test = ref_l.test;
  assign ld_prec  = ref_l.ld_prec;
  assign a_cnt    = ab_l.a;
  assign b_cnt    = ab_l.b;
  assign cp_gain  = ab_l.gain;
  assign mux_sel  = func_l.mux;
  assign pwr_dn   = func_l.pwr_dn;
  assign pd_pol   = func_l.pd_pol;
  assign cp_hiz   = func_l.cp_hiz;
  assign fl_en    = func_l.fl_en;
  assign fl_mode  = func_l.fl_mode;
  assign fl_timer = func_l.timer;

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(rst_core_n) |-> (!ctr_rst && !ref_err && ref_div == '0));
endmodule

// File: tb/syn_cfg_loader_bench.sv
`timescale 1ns/1ps
module syn_cfg_loader_bench;
  localparam int S = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, sle = 1'b0;

  logic [13:0] ref_div;
  logic [3:0]  ref_test;
  logic        ld_prec;
  logic [4:0]  a_cnt;
  logic [12:0] b_cnt;
  logic        cp_gain;
  logic [2:0]  mux_sel;
  logic [1:0]  pwr_dn;
  logic        pd_pol, cp_hiz, fl_en, fl_mode;
  logic [3:0]  fl_timer;
  logic        ctr_rst, ref_err;

  int checks = 0;
  int errors = 0;
  int ctr_cnt = 0;
  int err_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  syn_cfg_loader #(.SYNC_STAGES(S)) u_syn_cfg_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_data(sdat), .ser_le(sle),
    .ref_div(ref_div), .ref_test(ref_test), .ld_prec(ld_prec),
    .a_cnt(a_cnt), .b_cnt(b_cnt), .cp_gain(cp_gain),
    .mux_sel(mux_sel), .pwr_dn(pwr_dn), .pd_pol(pd_pol), .cp_hiz(cp_hiz),
    .fl_en(fl_en), .fl_mode(fl_mode), .fl_timer(fl_timer),
    .ctr_rst(ctr_rst), .ref_err(ref_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model: pin history queue plus expected fields
  logic [2:0]  hist [$];
  logic [20:0] m_sr;
  logic [13:0] m_div;
  logic [3:0]  m_test;
  logic        m_ldp, m_gain, m_ctr, m_err;
  logic [4:0]  m_a;
  logic [12:0] m_b;
  logic [12:0] m_func;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      m_sr = '0; m_div = '0; m_test = '0; m_ldp = 0; m_gain = 0;
      m_a = '0; m_b = '0; m_func = '0; m_ctr = 0; m_err = 0;
    end else begin
      m_ctr = 0;
      m_err = 0;
      hist.push_front({sle, sclk, sdat});
      if (hist.size() > S + 2) void'(hist.pop_back());
      if (hist.size() == S + 2) begin
        if (hist[S][2] && !hist[S+1][2]) begin
          case (m_sr[1:0])
            2'b00: if (m_sr[15:2] != 0) {m_ldp, m_test, m_div} = m_sr[20:2];
                   else m_err = 1;
            2'b01: {m_gain, m_b, m_a} = m_sr[20:2];
            2'b10: m_func = m_sr[14:2];
            default: begin m_func = m_sr[14:2]; m_ctr = 1; end
          endcase
        end
        if (hist[S][1] && !hist[S+1][1]) m_sr = {m_sr[19:0], hist[S][0]};
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 ref fields", {ld_prec, ref_test, ref_div}, {m_ldp, m_test, m_div});
      chk("R4 counter fields", {cp_gain, b_cnt, a_cnt}, {m_gain, m_b, m_a});
      chk("R5 function fields",
          {fl_timer, fl_mode, fl_en, cp_hiz, pd_pol, pwr_dn, mux_sel}, m_func);
      chk("R6 counter reset pulse", ctr_rst, m_ctr);
      chk("R7 reject flag", ref_err, m_err);
      if (ctr_rst) ctr_cnt++;
      if (ref_err) err_cnt++;
    end
  end

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sdat = v[i];
      repeat (2) @(negedge clk); sclk = 1'b1;
      repeat (3) @(negedge clk); sclk = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic strobe();
    repeat (2) @(negedge clk); sle = 1'b1;
    repeat (4) @(negedge clk); sle = 1'b0;
    repeat (S + 4) @(negedge clk);
  endtask

  task automatic write_word(input logic [20:0] w);
    shift_bits({11'd0, w}, 21);
    strobe();
  endtask

  function automatic logic [20:0] ref_word(input logic ldp, input logic [3:0] t,
                                           input logic [13:0] d);
    return {ldp, t, d, 2'b00};
  endfunction

  function automatic logic [20:0] fn_word(input logic [5:0] top, input logic [3:0] tmr,
      input logic flm, input logic fle, input logic hiz, input logic pol,
      input logic [1:0] pd, input logic [2:0] mx, input logic [1:0] dst);
    return {top, tmr, flm, fle, hiz, pol, pd, mx, dst};
  endfunction

  task automatic finish_up();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    // R1 reset state
    chk("R1 ref_div after reset", ref_div, 0);
    chk("R1 b_cnt after reset", b_cnt, 0);
    chk("R1 mux_sel after reset", mux_sel, 0);
    chk("R1 pulses after reset", {ctr_rst, ref_err}, 0);

    // R3 reference word, R2 MSB-first ordering
    write_word(ref_word(1'b1, 4'd0, 14'd1234));
    chk("R3 ref_div", ref_div, 1234);
    chk("R2 msb first ld_prec", ld_prec, 1);
    chk("R3 ref_test", ref_test, 0);

    // R8 shift without strobe, then R4 counter word
    shift_bits({11'd0, 1'b1, 13'd4000, 5'd17, 2'b01}, 21);
    repeat (10) @(negedge clk);
    chk("R8 a_cnt before strobe", a_cnt, 0);
    chk("R8 b_cnt before strobe", b_cnt, 0);
    strobe();
    chk("R4 a_cnt", a_cnt, 17);
    chk("R4 b_cnt", b_cnt, 4000);
    chk("R4 cp_gain", cp_gain, 1);
    chk("R8 ref untouched by counter word", ref_div, 1234);

    // R5 function word, unused top bits set
    write_word(fn_word(6'h3F, 4'd9, 1'b0, 1'b1, 1'b0, 1'b1, 2'b10, 3'd5, 2'b10));
    chk("R5 mux_sel", mux_sel, 5);
    chk("R5 pwr_dn", pwr_dn, 2'b10);
    chk("R5 pd_pol/cp_hiz", {pd_pol, cp_hiz}, 2'b10);
    chk("R5 fl_en/fl_mode", {fl_en, fl_mode}, 2'b10);
    chk("R5 fl_timer", fl_timer, 9);
    chk("R6 no reset pulse on function word", ctr_cnt, 0);
    chk("R8 counter untouched by function word", a_cnt, 17);

    // R6 initialization word
    write_word(fn_word(6'h00, 4'd3, 1'b1, 1'b0, 1'b1, 1'b0, 2'b01, 3'd2, 2'b11));
    chk("R6 fl_timer via init", fl_timer, 3);
    chk("R6 mux_sel via init", mux_sel, 2);
    chk("R6 single pulse", ctr_cnt, 1);

    // R7 zero divide rejected
    write_word(ref_word(1'b0, 4'b0101, 14'd0));
    chk("R7 ref_div kept", ref_div, 1234);
    chk("R7 ref_test kept", ref_test, 0);
    chk("R7 ld_prec kept", ld_prec, 1);
    chk("R7 single flag", err_cnt, 1);

    // R9 over-long shift: 4 extra leading ones
    shift_bits({7'd0, 4'b1111, ref_word(1'b0, 4'd0, 14'd7)}, 25);
    strobe();
    chk("R9 ref_div last 21 bits", ref_div, 7);
    chk("R9 ld_prec last 21 bits", {ld_prec, ref_test}, 0);

    // R3 maximum divide value
    write_word(ref_word(1'b0, 4'b1010, 14'd16383));
    chk("R3 max ref_div", ref_div, 16383);
    chk("R3 ref_test code", ref_test, 4'b1010);

    // R10 latency from pin edge
    shift_bits({11'd0, ref_word(1'b0, 4'd0, 14'd99)}, 21);
    repeat (2) @(negedge clk);
    sle = 1'b1;
    repeat (S) @(negedge clk);
    chk("R10 not yet updated", ref_div, 16383);
    @(negedge clk);
    chk("R10 updated on edge S+1", ref_div, 99);
    repeat (3) @(negedge clk);
    sle = 1'b0;
    repeat (6) @(negedge clk);

    finish_up();
  end
endmodule